// File: doc/BRIEF.md
# Cycle-Stealing Paged DMA Engine

This block moves a block of words between one peripheral and memory without help from the processor. Software first sets a start word address, a word count, a direction and a device identifier through a small register port. It then writes a go command. From then on the engine holds a bus request. It moves one word in each cycle where the bus arbiter grants the bus (a cycle the processor leaves idle) and the peripheral reports that it is ready. The memory address goes up by one after each word.

Physical memory behind a multi-page buffer need not be contiguous. The engine therefore follows a table of up to `CHAIN_DEPTH` page bases, written by software beforehand. When a word lands on the last word of a page, the next word goes to the start of the next page base in the table. If the table runs out while words remain, the transfer stops with an error. Normal completion or an error raises the interrupt, which stays high until software clears it.

Top module: `steal_dma`

## Requirements
- R1: Register map, word-indexed by `cfg_addr`, read combinationally on `cfg_rdata`:
  - 0 holds the start word address.
  - 1 holds the length in words.
  - 2 holds the control word: device id in bits [DEV_W-1:0], direction in bit 8 (0 = device to memory, 1 = memory to device).
  - 3 is the go command (write bit 0 = 1).
  - 4 is status: busy in bit 0, done in bit 1, error in bit 2.
  - 5 holds the chain length.
  - 8+i holds chain entry i.
  
  Registers 0, 1, 2, 5 and 8+i read back what was written.
- R2: A go command with a nonzero length, written while idle, sets busy in the following cycle. `bus_req` is high exactly while busy.
- R3: A word moves, with `mem_req` and `dev_ack` high together for one cycle, only in a cycle where `bus_gnt` and `dev_rdy` are both high. In any other cycle the address and remaining count are held.
- R4: Within one page, each word goes to the address one above the previous word.
- R5: With direction 0, each word taken from `dev_rdata` is written to memory (`mem_we` = 1). With direction 1, memory is read (`mem_we` = 0) and `mem_rdata` is passed to `dev_wdata`.
- R6: After a word at the last word of a page (offset bits all ones) with words still remaining, the next word goes to chain entry k with its page-offset bits forced to zero. k counts 0, 1, 2, … for each crossing.
- R7: If a crossing is needed when k equals the chain length (or `CHAIN_DEPTH`), the transfer stops after that page-end word. The error bit sets and done stays clear.
- R8: The last word of the count sets done and clears busy. `irq` equals done OR error. Each of these bits holds until a write to register 4 with a 1 in its bit position.
- R9: A go command written while busy is ignored. The running transfer keeps its address and count, and no other address is accessed.
- R10: A go command with length 0 sets done in the next cycle and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word index |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data (combinational) |
| irq | output | 1 | Interrupt: done or error |
| bus_req | output | 1 | Bus mastership request |
| bus_gnt | input | 1 | Grant for an idle bus cycle |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, same cycle |
| dev_id | output | DEV_W | Selected peripheral id |
| dev_dir | output | 1 | Transfer direction to peripheral |
| dev_rdy | input | 1 | Peripheral ready for a word |
| dev_ack | output | 1 | Word taken from or given to peripheral |
| dev_rdata | input | DATA_W | Data from peripheral |
| dev_wdata | output | DATA_W | Data to peripheral |

## Verification
The checker assumes three things about the environment:
- Memory returns read data in the same cycle as `mem_req`.
- The register port is the only means by which software clears the interrupt or restarts the engine.
- `bus_gnt` and `dev_rdy` may change in any cycle.

The bench drives `bus_gnt` and `dev_rdy` in fixed patterns from the falling clock edge: always high, alternating, and ready two cycles of three. It changes registers only through the register port, and its memory model answers combinationally. This keeps the stimulus inside those assumptions.

// File: rtl/steal_dma_pkg.sv
package steal_dma_pkg;

    localparam logic [3:0] REG_START = 4'd0;
    localparam logic [3:0] REG_LEN   = 4'd1;
    localparam logic [3:0] REG_CTRL  = 4'd2;
    localparam logic [3:0] REG_GO    = 4'd3;
    localparam logic [3:0] REG_STAT  = 4'd4;
    localparam logic [3:0] REG_CHLEN = 4'd5;
    localparam logic [3:0] REG_CHAIN = 4'd8;

    localparam int CTRL_DIR_BIT = 8;
    localparam int STAT_DONE_BIT = 1;
    localparam int STAT_ERR_BIT  = 2;

    typedef enum logic {
        DIR_DEV2MEM = 1'b0,
        DIR_MEM2DEV = 1'b1
    } xfer_dir_e;

    // bit 2 error, bit 1 done, bit 0 busy
    typedef struct packed {
        logic err;
        logic done;
        logic busy;
    } stat_t;

endpackage

// File: rtl/steal_dma_regs.sv
module steal_dma_regs
    import steal_dma_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int AW          = 20,
    parameter int CNT_W       = 16,
    parameter int DEV_W       = 4,
    parameter int CHAIN_DEPTH = 8,
    parameter int IDX_W       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [3:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  stat_t             stat,
    input  logic [IDX_W-1:0]  chain_idx,
    output logic [AW-1:0]     next_base,
    output logic [AW-1:0]     start_addr,
    output logic [CNT_W-1:0]  len,
    output xfer_dir_e         dir,
    output logic [DEV_W-1:0]  dev,
    output logic [IDX_W-1:0]  chain_len,
    output logic              go,
    output logic              clr_done,
    output logic              clr_err
);

    logic [AW-1:0] tbl [CHAIN_DEPTH];

    assign go       = cfg_wr && cfg_addr == REG_GO && cfg_wdata[0];
    assign clr_done = cfg_wr && cfg_addr == REG_STAT && cfg_wdata[STAT_DONE_BIT];
    assign clr_err  = cfg_wr && cfg_addr == REG_STAT && cfg_wdata[STAT_ERR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            start_addr <= '0;
            len        <= '0;
            dir        <= DIR_DEV2MEM;
            dev        <= '0;
            chain_len  <= '0;
        end else if (cfg_wr) begin
            case (cfg_addr)
                REG_START: start_addr <= cfg_wdata[AW-1:0];
                REG_LEN:   len        <= cfg_wdata[CNT_W-1:0];
                REG_CTRL: begin
                    dev <= cfg_wdata[DEV_W-1:0];
                    dir <= xfer_dir_e'(cfg_wdata[CTRL_DIR_BIT]);
                end
                REG_CHLEN: chain_len <= cfg_wdata[IDX_W-1:0];
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < CHAIN_DEPTH; i++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst)
                tbl[i] <= '0;
            else if (cfg_wr && cfg_addr == REG_CHAIN + 4'(i))
                tbl[i] <= cfg_wdata[AW-1:0];
        end
    end

    always_comb begin
        next_base = '0;
        for (int i = 0; i < CHAIN_DEPTH; i++)
            if (chain_idx == IDX_W'(i)) next_base = tbl[i];
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            REG_START: cfg_rdata = DATA_W'(start_addr);
            REG_LEN:   cfg_rdata = DATA_W'(len);
            REG_CTRL:  cfg_rdata = DATA_W'(dev) | (DATA_W'(dir) << CTRL_DIR_BIT);
            REG_STAT:  cfg_rdata = DATA_W'(stat);
            REG_CHLEN: cfg_rdata = DATA_W'(chain_len);
            default: begin
                for (int i = 0; i < CHAIN_DEPTH; i++)
                    if (cfg_addr == REG_CHAIN + 4'(i)) cfg_rdata = DATA_W'(tbl[i]);
            end
        endcase
    end

endmodule

// File: rtl/steal_dma_engine.sv
module steal_dma_engine
    import steal_dma_pkg::*;
#(
    parameter int AW          = 20,
    parameter int CNT_W       = 16,
    parameter int PAGE_WORDS  = 1024,
    parameter int CHAIN_DEPTH = 8,
    parameter int IDX_W       = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             clr_done,
    input  logic             clr_err,
    input  logic [AW-1:0]    start_addr,
    input  logic [CNT_W-1:0] len,
    input  logic [IDX_W-1:0] chain_len,
    input  logic [AW-1:0]    next_base,
    input  logic             bus_gnt,
    input  logic             dev_rdy,
    output logic [IDX_W-1:0] chain_idx,
    output logic [AW-1:0]    cur_addr,
    output logic             beat,
    output stat_t            stat
);

    localparam int OFF_W = $clog2(PAGE_WORDS);

    logic [CNT_W-1:0] remain;
    logic             page_end;
    logic             chain_ok;

    assign beat     = stat.busy && bus_gnt && dev_rdy;
    assign page_end = &cur_addr[OFF_W-1:0];
    assign chain_ok = (chain_idx < chain_len) && (chain_idx < IDX_W'(CHAIN_DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            stat      <= '0;
            cur_addr  <= '0;
            remain    <= '0;
            chain_idx <= '0;
        end else begin
            if (clr_done) stat.done <= 1'b0;
            if (clr_err)  stat.err  <= 1'b0;
            if (go && !stat.busy) begin
                stat.err  <= 1'b0;
                chain_idx <= '0;
                if (len == '0) begin
                    stat.done <= 1'b1;
                end else begin
                    stat.done <= 1'b0;
                    stat.busy <= 1'b1;
                    cur_addr  <= start_addr;
                    remain    <= len;
                end
            end else if (beat) begin
                remain   <= remain - 1'b1;
                cur_addr <= cur_addr + 1'b1;
                if (remain == CNT_W'(1)) begin
                    stat.busy <= 1'b0;
                    stat.done <= 1'b1;
                end else if (page_end) begin
                    if (chain_ok) begin
                        cur_addr  <= {next_base[AW-1:OFF_W], {OFF_W{1'b0}}};
                        chain_idx <= chain_idx + 1'b1;
                    end else begin
                        stat.busy <= 1'b0;
                        stat.err  <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/steal_dma.sv
module steal_dma
    import steal_dma_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int AW          = 20,
    parameter int CNT_W       = 16,
    parameter int DEV_W       = 4,
    parameter int PAGE_WORDS  = 1024,
    parameter int CHAIN_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [3:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              irq,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DEV_W-1:0]  dev_id,
    output logic              dev_dir,
    input  logic              dev_rdy,
    output logic              dev_ack,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic [DATA_W-1:0] dev_wdata
);

    localparam int IDX_W = $clog2(CHAIN_DEPTH + 1);

    logic [AW-1:0]    start_addr;
    logic [AW-1:0]    next_base;
    logic [CNT_W-1:0] len;
    logic [IDX_W-1:0] chain_len;
    logic [IDX_W-1:0] chain_idx;
    xfer_dir_e        dir;
    logic             go, clr_done, clr_err, beat;
    stat_t            stat;

    steal_dma_regs #(
        .DATA_W(DATA_W), .AW(AW), .CNT_W(CNT_W), .DEV_W(DEV_W),
        .CHAIN_DEPTH(CHAIN_DEPTH), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .stat(stat),
        .chain_idx(chain_idx), .next_base(next_base), .start_addr(start_addr),
        .len(len), .dir(dir), .dev(dev_id), .chain_len(chain_len), .go(go),
        .clr_done(clr_done), .clr_err(clr_err)
    );

    steal_dma_engine #(
        .AW(AW), .CNT_W(CNT_W), .PAGE_WORDS(PAGE_WORDS),
        .CHAIN_DEPTH(CHAIN_DEPTH), .IDX_W(IDX_W)
    ) u_eng (
        .clk(clk), .rst(rst), .go(go), .clr_done(clr_done), .clr_err(clr_err),
        .start_addr(start_addr), .len(len), .chain_len(chain_len),
        .next_base(next_base), .bus_gnt(bus_gnt), .dev_rdy(dev_rdy),
        .chain_idx(chain_idx), .cur_addr(mem_addr), .beat(beat), .stat(stat)
    );

    assign irq       = stat.done || stat.err;
    assign bus_req   = stat.busy;
    assign mem_req   = beat;
    assign dev_ack   = beat;
    assign mem_we    = (dir == DIR_DEV2MEM);
    assign dev_dir   = dir;
    assign mem_wdata = dev_rdata;
    assign dev_wdata = mem_rdata;

endmodule

// File: rtl/steal_dma_chk.sv
module steal_dma_chk
    import steal_dma_pkg::*;
#(
    parameter int AW         = 20,
    parameter int PAGE_WORDS = 1024
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_wr,
    input logic [3:0]    cfg_addr,
    input logic [1:0]    clr_bits,
    input logic          irq,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          dev_rdy,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr
);

    localparam int OFF_W = $clog2(PAGE_WORDS);

    logic [AW-1:0] last_addr;
    logic          has_last;

    always_ff @(posedge clk) begin
        if (rst || !bus_req) begin
            has_last  <= 1'b0;
            last_addr <= '0;
        end else if (mem_req) begin
            has_last  <= 1'b1;
            last_addr <= mem_addr;
        end
    end

    // R3
    beat_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (bus_gnt && dev_rdy && bus_req));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && has_last && !(&last_addr[OFF_W-1:0])) |-> mem_addr == last_addr + 1'b1);

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !(cfg_wr && ((cfg_addr == REG_STAT && clr_bits != 2'b00) || cfg_addr == REG_GO)))
        |=> irq);

    // R8
    irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> !bus_req);

    // R2
    end_raises_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req) |-> irq);

endmodule

bind steal_dma steal_dma_chk #(.AW(AW), .PAGE_WORDS(PAGE_WORDS)) u_chk (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .clr_bits(cfg_wdata[2:1]), .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .dev_rdy(dev_rdy), .mem_req(mem_req), .mem_addr(mem_addr)
);

// File: tb/sim_steal_dma.sv
module sim_steal_dma;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 10;
    localparam int PAGE = 16;
    localparam int MEMN = 1 << AW;

    logic clk = 0, rst = 1;
    logic cfg_wr = 0;
    logic [3:0] cfg_addr = 0;
    logic [DW-1:0] cfg_wdata = 0, cfg_rdata;
    logic irq, bus_req, mem_req, mem_we, dev_dir, dev_ack;
    logic bus_gnt, dev_rdy;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata, dev_wdata, dev_rdata;
    logic [3:0] dev_id;

    int checks = 0, errors = 0;
    int cyc = 0, gmode = 0, rmode = 0;
    int beats = 0, bad_beats = 0, dev_cnt = 0;
    logic fill_go = 0;
    int fill_lo = 0, fill_hi = 0;
    logic [DW-1:0] fill_val = 0;
    logic fill_inc = 0, devclr = 0;
    logic [DW-1:0] mem [MEMN];
    logic [DW-1:0] cap [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    steal_dma #(.DATA_W(DW), .AW(AW), .CNT_W(16), .DEV_W(4),
                .PAGE_WORDS(PAGE), .CHAIN_DEPTH(8)) u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_id(dev_id), .dev_dir(dev_dir), .dev_rdy(dev_rdy), .dev_ack(dev_ack),
        .dev_rdata(dev_rdata), .dev_wdata(dev_wdata)
    );

    always @(negedge clk) cyc <= cyc + 1;
    assign bus_gnt = (gmode == 1) ? cyc[0] : 1'b1;
    assign dev_rdy = (rmode == 1) ? ((cyc % 3) != 0) : 1'b1;
    assign mem_rdata = mem[mem_addr];
    assign dev_rdata = 32'hA000 + dev_cnt;

    always @(posedge clk) begin
        if (fill_go) begin
            for (int i = 0; i < MEMN; i++)
                if (i >= fill_lo && i <= fill_hi)
                    mem[i] <= fill_inc ? fill_val + DW'(i - fill_lo) : fill_val;
        end else if (mem_req && mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end
    end

    always @(posedge clk) begin
        if (devclr) begin
            dev_cnt <= 0; beats <= 0; bad_beats <= 0;
        end else if (mem_req) begin
            beats <= beats + 1;
            if (!(bus_gnt && dev_rdy) || !dev_ack) bad_beats <= bad_beats + 1;
            if (dev_ack) begin
                if (dev_cnt < 64) cap[dev_cnt] <= dev_wdata;
                dev_cnt <= dev_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic fill(input int lo, input int hi, input logic [DW-1:0] v, input logic inc);
        @(negedge clk);
        fill_lo = lo; fill_hi = hi; fill_val = v; fill_inc = inc; fill_go = 1;
        @(negedge clk);
        fill_go = 0;
    endtask

    task automatic clear_dev();
        @(negedge clk); devclr = 1;
        @(negedge clk); devclr = 0;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 2000) begin @(negedge clk); n++; end
        chk(req, {31'd0, irq}, 1);
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        rd(4'd4, d);
        chk("R8 reset status", d, 0);
        chk("R2 reset bus_req", {31'd0, bus_req}, 0);
        chk("R8 reset irq", {31'd0, irq}, 0);
    endtask

    task automatic t_regs();
        logic [DW-1:0] d;
        wr(4'd0, 32'h123); rd(4'd0, d); chk("R1 start readback", d, 32'h123);
        wr(4'd1, 32'd7); rd(4'd1, d); chk("R1 length readback", d, 7);
        wr(4'd2, 32'h105); rd(4'd2, d); chk("R1 ctrl readback", d, 32'h105);
        chk("R1 dev_id port", {28'd0, dev_id}, 4'h5);
        wr(4'd5, 32'd3); rd(4'd5, d); chk("R1 chain length readback", d, 3);
        wr(4'd9, 32'h2A0); rd(4'd9, d); chk("R1 chain entry readback", d, 32'h2A0);
    endtask

    task automatic t_dev2mem();
        logic [DW-1:0] d;
        gmode = 0; rmode = 0;
        fill(32'h20, 32'h26, 32'hDEAD, 0);
        clear_dev();
        wr(4'd0, 32'h20); wr(4'd1, 32'd5); wr(4'd2, 32'h003);
        @(negedge clk); cfg_wr = 1; cfg_addr = 4'd3; cfg_wdata = 1;
        @(negedge clk); cfg_wr = 0;
        chk("R2 bus_req after go", {31'd0, bus_req}, 1);
        wait_irq("R8 irq after dev2mem");
        for (int k = 0; k < 5; k++) chk("R4 R5 dev2mem word", mem[32'h20 + k], 32'hA000 + k);
        chk("R4 word past end untouched", mem[32'h25], 32'hDEAD);
        rd(4'd4, d); chk("R8 status done", d, 32'h2);
        chk("R2 bus_req idle", {31'd0, bus_req}, 0);
        wr(4'd4, 32'h2);
        @(negedge clk); chk("R8 irq cleared", {31'd0, irq}, 0);
    endtask

    task automatic t_mem2dev();
        gmode = 1; rmode = 1;
        fill(32'h40, 32'h47, 32'h5500, 1);
        clear_dev();
        wr(4'd0, 32'h40); wr(4'd1, 32'd8); wr(4'd2, 32'h100);
        wr(4'd3, 32'd1);
        wait_irq("R8 irq after mem2dev");
        chk("R5 mem2dev word count", dev_cnt, 8);
        for (int k = 0; k < 8; k++) chk("R3 R5 mem2dev word order", cap[k], 32'h5500 + k);
        chk("R3 no beat without grant and ready", bad_beats, 0);
        chk("R5 memory not written", mem[32'h40], 32'h5500);
        wr(4'd4, 32'h2);
        gmode = 0; rmode = 0;
    endtask

    task automatic t_chain();
        fill(0, MEMN - 1, 32'h0, 0);
        clear_dev();
        wr(4'd5, 32'd2); wr(4'd8, 32'h105); wr(4'd9, 32'h200);
        wr(4'd0, 32'h0E); wr(4'd1, 32'd22); wr(4'd2, 32'h000);
        wr(4'd3, 32'd1);
        wait_irq("R6 irq after chain");
        chk("R6 first page word", mem[32'h0F], 32'hA001);
        chk("R6 next page not linear", mem[32'h10], 32'h0);
        chk("R6 entry0 offset forced zero", mem[32'h100], 32'hA002);
        chk("R6 entry0 last word", mem[32'h10F], 32'hA011);
        chk("R6 entry1 first word", mem[32'h200], 32'hA012);
        chk("R6 entry1 last word", mem[32'h203], 32'hA015);
        chk("R6 total words", beats, 22);
        wr(4'd4, 32'h2);
    endtask

    task automatic t_exhaust();
        logic [DW-1:0] d;
        fill(32'h3C, 32'h45, 32'hBEEF, 0);
        clear_dev();
        wr(4'd5, 32'd0);
        wr(4'd0, 32'h3C); wr(4'd1, 32'd10); wr(4'd3, 32'd1);
        wait_irq("R7 irq on error");
        rd(4'd4, d); chk("R7 status error only", d, 32'h4);
        chk("R7 words before abort", beats, 4);
        chk("R7 word at page end", mem[32'h3F], 32'hA003);
        chk("R7 next linear word untouched", mem[32'h40], 32'hBEEF);
        repeat (5) @(negedge clk);
        chk("R8 irq held until cleared", {31'd0, irq}, 1);
        wr(4'd4, 32'h2);
        chk("R8 done clear leaves error irq", {31'd0, irq}, 1);
        wr(4'd4, 32'h4);
        chk("R8 irq cleared by error write", {31'd0, irq}, 0);
    endtask

    task automatic t_busy_go();
        fill(32'h80, 32'h9F, 32'h7777, 0);
        clear_dev();
        gmode = 1;
        wr(4'd0, 32'h80); wr(4'd1, 32'd6); wr(4'd3, 32'd1);
        wr(4'd0, 32'h90); wr(4'd3, 32'd1);
        wait_irq("R9 irq after run");
        chk("R9 words moved", beats, 6);
        chk("R9 first run last word", mem[32'h85], 32'hA005);
        chk("R9 second address untouched", mem[32'h90], 32'h7777);
        chk("R9 after end untouched", mem[32'h86], 32'h7777);
        wr(4'd4, 32'h2);
        gmode = 0;
    endtask

    task automatic t_zero_len();
        logic [DW-1:0] d;
        clear_dev();
        wr(4'd1, 32'd0); wr(4'd3, 32'd1);
        rd(4'd4, d); chk("R10 zero length done", d, 32'h2);
        chk("R10 no memory access", beats, 0);
        chk("R10 bus_req stays low", {31'd0, bus_req}, 0);
        wr(4'd4, 32'h2);
    endtask

    initial begin
        bit timed_out = 0;
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 0;
                t_reset();
                t_regs();
                t_dev2mem();
                t_mem2dev();
                t_chain();
                t_exhaust();
                t_busy_go();
                t_zero_len();
            end
            begin
                repeat (100000) @(negedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule